// File: doc/BRIEF.md
# Two-Button Binary Combination Lock

This block is a push-button lock. A user enters binary digits on two buttons, one meaning 0 and one meaning 1. A single output opens the lock once the secret five-digit sequence 0,1,0,1,1 has been entered. A third button clears any partial entry and returns the lock to its start.

Each raw button level passes through a two-flop synchronizer. The synchronized digit buttons are then turned into one-cycle press pulses, so a press advances the machine exactly once, however long the button is held. The core is a Moore machine with six states held in three bits: start, and one state for each matched prefix of the code. The open output is decoded from the state alone.

When a wrong digit arrives, the machine keeps the longest tail of the digits entered so far that is still a leading part of the code. A partly correct entry therefore does not have to be started over.

Top module: `combo_lock`

## Requirements
- R1: While `rst_n` is low, the lock is in the start state and `unlock_o` is 0. This reset is asynchronous.
- R2: Pressing the buttons in the order 0,1,0,1,1 from the start state drives `unlock_o` to 1.
- R3: `unlock_o` is 1 only after the full code. From the open state, a further 0 press moves to the state "0" and a further 1 press moves to start. Either press drives `unlock_o` back to 0.
- R4: A wrong digit moves the machine to the state for the longest suffix of the entered digits that is also a prefix of the code. A 0 in state "0" stays in "0". A 1 in start stays in start. A 1 in "01" goes to start. A 0 in "010" goes to "0". A 0 in "0101" goes to "010".
- R5: A press counts as one digit no matter how many cycles the button is held.
- R6: If both digit pulses occur in the same cycle, the machine goes to the start state.
- R7: `clear_i` is active high and synchronous, and it returns the machine to start. It takes priority over a digit pulse in the same cycle.
- R8: For the final press of the code, `unlock_o` is still 0 two rising edges after the button input rises. It becomes 1 after the third rising edge: two synchronizer flops, then the state register.
- R9: When no digit pulse and no clear occur, the state and `unlock_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| btn0_i | input | 1 | Raw level of the digit-0 button |
| btn1_i | input | 1 | Raw level of the digit-1 button |
| clear_i | input | 1 | Raw level of the clear button, active high |
| unlock_o | output | 1 | 1 when the lock is open |

## Verification
A button edge reaches the state register on the third rising clock edge after the input changes, and `unlock_o` follows on the same edge. Most checks therefore release the button and wait six cycles before sampling `unlock_o` at a falling edge, so every pulse has settled. The latency check for R8 and the clear-priority check for R7 sample exactly two and three falling edges after the input rises. They expect 0 on the second sample and the new value on the third. The reset check for R1 samples one nanosecond after `rst_n` falls, with no clock edge in between.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_START = 3'd0,
    ST_P1    = 3'd1,  // matched "0"
    ST_P2    = 3'd2,  // matched "01"
    ST_P3    = 3'd3,  // matched "010"
    ST_P4    = 3'd4,  // matched "0101"
    ST_OPEN  = 3'd5   // matched full code
  } lock_state_e;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= raw_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw_i};
      end
    end
  endgenerate

  assign lvl_o = chain_q[STAGES-1];
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~prev_q;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        dig0_i,
  input  logic        dig1_i,
  output lock_state_e state_o,
  output logic        open_o
);
  lock_state_e state_q, state_d;
  logic        state_en;

  // update only on an event: a clear or a digit pulse
  assign state_en = clr_i | dig0_i | dig1_i;

  always_comb begin
    state_d = state_q;
    if (clr_i) begin
      state_d = ST_START;
    end else if (dig0_i && dig1_i) begin
      state_d = ST_START;
    end else if (dig0_i) begin
      unique case (state_q)
        ST_START: state_d = ST_P1;
        ST_P1:    state_d = ST_P1;
        ST_P2:    state_d = ST_P3;
        ST_P3:    state_d = ST_P1;
        ST_P4:    state_d = ST_P3;
        ST_OPEN:  state_d = ST_P1;
        default:  state_d = ST_START;
      endcase
    end else if (dig1_i) begin
      unique case (state_q)
        ST_START: state_d = ST_START;
        ST_P1:    state_d = ST_P2;
        ST_P2:    state_d = ST_START;
        ST_P3:    state_d = ST_P4;
        ST_P4:    state_d = ST_OPEN;
        ST_OPEN:  state_d = ST_START;
        default:  state_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= ST_START;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;
  assign open_o  = (state_q == ST_OPEN);
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn0_i,
  input  logic btn1_i,
  input  logic clear_i,
  output logic unlock_o
);
  localparam int NUM_DIG = 2;

  logic [NUM_DIG-1:0] raw_dig;
  logic [NUM_DIG-1:0] lvl_dig;
  logic [NUM_DIG-1:0] pulse;
  logic               clr_lvl;
  lock_state_e        state_q;

  assign raw_dig = {btn1_i, btn0_i};

  generate
    for (genvar i = 0; i < NUM_DIG; i++) begin : g_dig
      btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(raw_dig[i]), .lvl_o(lvl_dig[i])
      );
      rise_pulse u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_dig[i]), .pulse_o(pulse[i])
      );
    end
  endgenerate

  btn_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(clear_i), .lvl_o(clr_lvl)
  );

  lock_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_lvl),
    .dig0_i(pulse[0]), .dig1_i(pulse[1]),
    .state_o(state_q), .open_o(unlock_o)
  );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk
  import lock_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  pulse,
  input logic        clr_lvl,
  input lock_state_e state_q,
  input logic        unlock_o
);
  // R2: opening only follows a lone 1 pulse in state "0101"
  p_open_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_o) |-> ($past(state_q) == ST_P4 && $past(pulse) == 2'b10 && !$past(clr_lvl)));

  // R3: a lone 1 press while open returns to start
  p_open_leave_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPEN && pulse == 2'b10 && !clr_lvl) |=> (state_q == ST_START && !unlock_o));

  // R4: the state register never holds an unused code
  p_legal_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_START, ST_P1, ST_P2, ST_P3, ST_P4, ST_OPEN});

  // R5: press pulses last a single cycle
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |pulse |=> (pulse & $past(pulse)) == 2'b00);

  // R6: simultaneous digits go to start
  p_both_digits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse == 2'b11) |=> state_q == ST_START);

  // R7: clear wins over any digit
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_lvl |=> state_q == ST_START);

  // R9: no event, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse == 2'b00 && !clr_lvl) |=> $stable(state_q));
endmodule

bind combo_lock combo_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pulse(pulse), .clr_lvl(clr_lvl),
  .state_q(state_q), .unlock_o(unlock_o)
);

// File: tb/tb_combo_lock.sv
`timescale 1ns/1ps
module tb_combo_lock;
  logic clk = 1'b0;
  logic rst_n;
  logic btn0, btn1, clr;
  logic unlock;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int          model  = 0;
  bit          done   = 0;

  always #2 clk = ~clk;

  combo_lock dut (
    .clk(clk), .rst_n(rst_n), .btn0_i(btn0), .btn1_i(btn1),
    .clear_i(clr), .unlock_o(unlock)
  );

  // start=0, "0"=1, "01"=2, "010"=3, "0101"=4, open=5
  function automatic int nxt(int s, bit d0, bit d1);
    int r;
    r = s;
    if (d0 && d1) r = 0;
    else if (d0) begin
      case (s)
        0: r = 1; 1: r = 1; 2: r = 3; 3: r = 1; 4: r = 3; default: r = 1;
      endcase
    end else if (d1) begin
      case (s)
        0: r = 0; 1: r = 2; 2: r = 0; 3: r = 4; 4: r = 5; default: r = 0;
      endcase
    end
    return r;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: unlock=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic press(bit d0, bit d1, int hold, string req);
    btn0 = d0; btn1 = d1;
    step(hold);
    btn0 = 1'b0; btn1 = 1'b0;
    step(6);
    model = nxt(model, d0, d1);
    chk(req, unlock, model == 5);
  endtask

  task automatic do_clear(int hold);
    clr = 1'b1; step(hold); clr = 1'b0; step(6);
    model = 0;
    chk("R7", unlock, 1'b0);
  endtask

  task automatic enter_code(string req);
    press(1, 0, 2, req); press(0, 1, 2, req); press(1, 0, 2, req);
    press(0, 1, 2, req); press(0, 1, 2, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    int r;
    void'($urandom(32'h0001_5EED));
    rst_n = 1'b0; btn0 = 1'b0; btn1 = 1'b0; clr = 1'b0;
    step(3);
    chk("R1", unlock, 1'b0);
    rst_n = 1'b1;
    step(2);
    model = 0;
    chk("R1", unlock, 1'b0);

    // R2 basic code
    enter_code("R2");
    chk("R2", unlock, 1'b1);
    // R3 leave by 1
    press(0, 1, 2, "R3");
    // R3 leave by 0, then resume from "0": 1,0,1,1 opens
    enter_code("R2");
    press(1, 0, 2, "R3");
    press(0, 1, 2, "R3"); press(1, 0, 2, "R3");
    press(0, 1, 2, "R3"); press(0, 1, 2, "R3");
    chk("R3", unlock, 1'b1);

    // R4 fallbacks: 0101 then 0 -> 010, then 1,1 opens
    do_clear(2);
    press(1, 0, 2, "R4"); press(0, 1, 2, "R4"); press(1, 0, 2, "R4");
    press(0, 1, 2, "R4"); press(1, 0, 2, "R4");
    press(0, 1, 2, "R4"); press(0, 1, 2, "R4");
    chk("R4", unlock, 1'b1);
    // 0,0 stays in "0": 0,0,1,0,1,1 opens
    do_clear(2);
    press(1, 0, 2, "R4"); press(1, 0, 2, "R4"); press(0, 1, 2, "R4");
    press(1, 0, 2, "R4"); press(0, 1, 2, "R4"); press(0, 1, 2, "R4");
    chk("R4", unlock, 1'b1);
    // 01 then 1 -> start: 0,1,1,0,1,1 stays shut
    do_clear(2);
    press(1, 0, 2, "R4"); press(0, 1, 2, "R4"); press(0, 1, 2, "R4");
    press(1, 0, 2, "R4"); press(0, 1, 2, "R4"); press(0, 1, 2, "R4");
    chk("R4", unlock, 1'b0);

    // R5 long hold of the second digit counts once
    do_clear(2);
    press(1, 0, 2, "R5"); press(0, 1, 25, "R5"); press(1, 0, 2, "R5");
    press(0, 1, 2, "R5"); press(0, 1, 30, "R5");
    chk("R5", unlock, 1'b1);

    // R6 both digits together from "0101"
    do_clear(2);
    press(1, 0, 2, "R6"); press(0, 1, 2, "R6"); press(1, 0, 2, "R6");
    press(0, 1, 2, "R6");
    press(1, 1, 3, "R6");
    press(0, 1, 2, "R6");
    chk("R6", unlock, 1'b0);

    // R8 latency of final press
    do_clear(2);
    press(1, 0, 2, "R8"); press(0, 1, 2, "R8"); press(1, 0, 2, "R8");
    press(0, 1, 2, "R8");
    btn1 = 1'b1;
    step(2); chk("R8", unlock, 1'b0);
    step(1); chk("R8", unlock, 1'b1);
    btn1 = 1'b0; step(6); model = 5;
    // R9 idle holds
    step(20); chk("R9", unlock, 1'b1);

    // R7 clear together with final digit
    do_clear(2);
    press(1, 0, 2, "R7"); press(0, 1, 2, "R7"); press(1, 0, 2, "R7");
    press(0, 1, 2, "R7");
    btn1 = 1'b1; clr = 1'b1;
    step(3); chk("R7", unlock, 1'b0);
    btn1 = 1'b0; clr = 1'b0; step(6); model = 0;
    chk("R7", unlock, 1'b0);

    // R1 async reset while open
    enter_code("R1");
    @(negedge clk); #1 rst_n = 1'b0;
    #1 chk("R1", unlock, 1'b0);
    @(negedge clk); rst_n = 1'b1; model = 0; step(2);

    // random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom % 16;
      if (r < 6)       press(1, 0, 1 + $urandom % 5, "R4");
      else if (r < 12) press(0, 1, 1 + $urandom % 5, "R4");
      else if (r == 12) press(1, 1, 1 + $urandom % 3, "R6");
      else if (r == 13) do_clear(1 + $urandom % 3);
      else if (r == 14) begin step(1 + $urandom % 8); chk("R9", unlock, model == 5); end
      else enter_code("R2");
    end

    finish_run();
  end
endmodule